// File: doc/BRIEF.md
# Radio Transceiver Mode Sequencer

This block drives an external sub-GHz radio between its operating modes: power-down, reset, waking the receive or transmit chain, arming the receive or transmit path, and calibrating the synthesizer. Each mode is a fixed script of register writes and status reads, issued one at a time over a request/acknowledge register-access port. A serial engine on the far side of that port moves the bytes on the wire. Timed waits stand in for oscillator start-up and settling. The status polls wait for calibration to complete and for the synthesizer to lock.

Software or a higher-level controller pulses a command and supplies two bytes: an analog bias value and a power-amplifier level. The sequencer reports busy until the script ends. It then pulses a done strobe together with a result code. When a lock poll runs out of attempts, the sequencer runs a full calibration and continues the original script. The result code tells apart three outcomes: lock on the first try, lock only after recalibration, and no lock.

Top module: `radio_mode_seq`

## Requirements
- R1: Command 1 (power-down) writes 0x1F to register 0x00 (main control) and then 0x00 to register 0x02 (amplifier level). It finishes with result code 0 (none) and makes no status read.
- R2: Command 2 (reset) writes 0x0E to register 0x00 and then 0x1F to register 0x00.
- R3: Command 3 (receive wake) performs these steps in order:
  - writes 0x1B to register 0x00;
  - writes the bias byte to register 0x03;
  - idles LONG_WAIT cycles;
  - writes 0x19 to register 0x00;
  - idles SHORT_WAIT cycles;
  - writes 0x11 to register 0x00.
- R4: Command 5 (transmit wake) performs these steps in order:
  - writes 0xDB to register 0x00;
  - writes the bias byte to register 0x03;
  - idles LONG_WAIT cycles;
  - writes 0xD9 to register 0x00;
  - idles two SHORT_WAIT periods back to back;
  - writes 0xD1 to register 0x00.
- R5: Command 4 (receive setup) performs these steps in order:
  - writes 0x11 to register 0x00;
  - writes the bias byte to register 0x03;
  - idles SHORT_WAIT cycles;
  - runs a lock poll;
  - writes 0x01 to register 0x00;
  - writes 0x02 to register 0x01 (interface).
- R6: Command 6 (transmit setup) performs these steps in order:
  - writes the bias byte to register 0x03;
  - writes 0xC1 to register 0x00;
  - idles SHORT_WAIT cycles;
  - runs a lock poll;
  - writes the amplifier byte to register 0x02;
  - writes 0x01 to register 0x01.
- R7: A lock poll reads status register 0x05 repeatedly. Bit 4 is the lock flag. The poll stops at the first read that shows the flag set and makes at most LOCK_TIMEOUT reads. A setup that locks within the poll finishes with result code 1 (locked).
- R8: Command 7 (calibrate) performs these steps in order:
  - writes 0x00 to register 0x02;
  - writes 0xB5 to register 0x04;
  - idles LONG_WAIT cycles;
  - reads status until bit 7 (calibration complete) is set;
  - idles SHORT_WAIT cycles;
  - runs a lock poll that ends after LOCK_TIMEOUT reads whatever the flag shows;
  - writes the amplifier byte to register 0x02;
  - makes one final status read.

  The result is 1 if the final read shows bit 4 set and 3 (failed) otherwise.
- R9: When the lock poll of a setup command ends without lock, the sequencer runs the full R8 sequence and then the rest of the setup script. The result is 2 (locked after recalibration) if the final read of that calibration shows lock, and 3 otherwise.
- R10: Only one register request is outstanding at a time. Once raised, the request stays high with stable direction, address and write data until the cycle in which acknowledge is high. Read data is taken in that cycle. Reads address only register 0x05, and writes address only registers 0x00 to 0x04.
- R11: Busy is low after reset and rises in the cycle after a command is accepted. It stays high until the cycle in which done pulses for one cycle. The result code is updated with done and held until the next done.
- R12: A command presented while busy is high is ignored and not queued. Command code 0 is ignored.
- R13: The bias and amplifier bytes are captured when a command is accepted. Later changes on those inputs do not affect that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code (1 power-down, 2 reset, 3 receive wake, 4 receive setup, 5 transmit wake, 6 transmit setup, 7 calibrate) |
| analog_i | input | 8 | Analog bias byte |
| pa_i | input | 8 | Amplifier level byte |
| req_o | output | 1 | Register access request |
| req_we_o | output | 1 | Request is a write (1) or a status read (0) |
| req_addr_o | output | 7 | Register address |
| req_wdata_o | output | 8 | Write data |
| ack_i | input | 1 | Request completed this cycle |
| rdata_i | input | 8 | Read data, valid with ack_i |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 2 | 0 none, 1 locked, 2 locked after recalibration, 3 failed |

## Verification
The bench sweeps the read on which lock appears across every position inside the lock-poll window. A poll counter that is off by one would either fall into recalibration one read early or make one read too many. Two cases push the poll past its window, one where lock returns during recalibration and one where it never returns. A wrong return point or result code would repeat or skip setup writes, or report 1 where 2 or 3 is due. The bench also sweeps how many reads the calibration-complete bit takes to appear, and it measures the idle gaps around each wait. Finally it changes the bias and amplifier inputs, and issues a second command, while a script is running. A design that did not capture the bytes at accept, or that queued the late command, would write the wrong bytes or start a second script.

// File: rtl/radio_seq_pkg.sv
`timescale 1ns/1ps
package radio_seq_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int PC_W   = 6;

  localparam logic [ADDR_W-1:0] REG_MAIN   = 7'h00;
  localparam logic [ADDR_W-1:0] REG_IFACE  = 7'h01;
  localparam logic [ADDR_W-1:0] REG_PA     = 7'h02;
  localparam logic [ADDR_W-1:0] REG_ANALOG = 7'h03;
  localparam logic [ADDR_W-1:0] REG_CAL    = 7'h04;
  localparam logic [ADDR_W-1:0] REG_STATUS = 7'h05;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_PDOWN, CMD_RESET, CMD_WAKE_RX,
    CMD_SETUP_RX, CMD_WAKE_TX, CMD_SETUP_TX, CMD_CAL
  } cmd_e;

  typedef enum logic [1:0] {RES_NONE, RES_LOCK, RES_RECAL, RES_FAIL} res_e;

  typedef enum logic [2:0] {
    K_WR, K_WAIT_L, K_WAIT_S, K_POLL_CAL,
    K_POLL_LOCK, K_POLL_LOCK_CAL, K_FINAL, K_END
  } kind_e;

  typedef enum logic [1:0] {SRC_K, SRC_AN, SRC_PA} src_e;

  typedef struct packed {
    kind_e             kind;
    logic [ADDR_W-1:0] addr;
    src_e              src;
    logic [DATA_W-1:0] data;
  } step_t;

  // script entry points
  localparam logic [PC_W-1:0] PC_PDOWN    = 6'd0;
  localparam logic [PC_W-1:0] PC_RESET    = 6'd3;
  localparam logic [PC_W-1:0] PC_WAKE_RX  = 6'd6;
  localparam logic [PC_W-1:0] PC_WAKE_TX  = 6'd13;
  localparam logic [PC_W-1:0] PC_SETUP_RX = 6'd21;
  localparam logic [PC_W-1:0] PC_SETUP_TX = 6'd28;
  localparam logic [PC_W-1:0] PC_CAL      = 6'd35;
endpackage

// File: rtl/radio_seq_rom.sv
`timescale 1ns/1ps
module radio_seq_rom
  import radio_seq_pkg::*;
(
  input  logic [PC_W-1:0] pc_i,
  input  logic [2:0]      cmd_i,
  output step_t           step_o,
  output logic [PC_W-1:0] start_pc_o
);
  function automatic step_t wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    return '{kind: K_WR, addr: a, src: SRC_K, data: d};
  endfunction

  function automatic step_t op(input kind_e k);
    return '{kind: k, addr: REG_STATUS, src: SRC_K, data: '0};
  endfunction

  localparam step_t WR_AN = '{kind: K_WR, addr: REG_ANALOG, src: SRC_AN, data: '0};
  localparam step_t WR_PA = '{kind: K_WR, addr: REG_PA,     src: SRC_PA, data: '0};

  always_comb begin
    unique case (cmd_i)
      3'(CMD_PDOWN):    start_pc_o = PC_PDOWN;
      3'(CMD_RESET):    start_pc_o = PC_RESET;
      3'(CMD_WAKE_RX):  start_pc_o = PC_WAKE_RX;
      3'(CMD_SETUP_RX): start_pc_o = PC_SETUP_RX;
      3'(CMD_WAKE_TX):  start_pc_o = PC_WAKE_TX;
      3'(CMD_SETUP_TX): start_pc_o = PC_SETUP_TX;
      3'(CMD_CAL):      start_pc_o = PC_CAL;
      default:          start_pc_o = PC_PDOWN;
    endcase
  end

  always_comb begin
    unique case (pc_i)
      // power-down
      6'd0:  step_o = wr(REG_MAIN, 8'h1F);
      6'd1:  step_o = wr(REG_PA, 8'h00);
      // reset pulse
      6'd3:  step_o = wr(REG_MAIN, 8'h0E);
      6'd4:  step_o = wr(REG_MAIN, 8'h1F);
      // receive wake
      6'd6:  step_o = wr(REG_MAIN, 8'h1B);
      6'd7:  step_o = WR_AN;
      6'd8:  step_o = op(K_WAIT_L);
      6'd9:  step_o = wr(REG_MAIN, 8'h19);
      6'd10: step_o = op(K_WAIT_S);
      6'd11: step_o = wr(REG_MAIN, 8'h11);
      // transmit wake
      6'd13: step_o = wr(REG_MAIN, 8'hDB);
      6'd14: step_o = WR_AN;
      6'd15: step_o = op(K_WAIT_L);
      6'd16: step_o = wr(REG_MAIN, 8'hD9);
      6'd17: step_o = op(K_WAIT_S);
      6'd18: step_o = op(K_WAIT_S);
      6'd19: step_o = wr(REG_MAIN, 8'hD1);
      // receive setup
      6'd21: step_o = wr(REG_MAIN, 8'h11);
      6'd22: step_o = WR_AN;
      6'd23: step_o = op(K_WAIT_S);
      6'd24: step_o = op(K_POLL_LOCK);
      6'd25: step_o = wr(REG_MAIN, 8'h01);
      6'd26: step_o = wr(REG_IFACE, 8'h02);
      // transmit setup
      6'd28: step_o = WR_AN;
      6'd29: step_o = wr(REG_MAIN, 8'hC1);
      6'd30: step_o = op(K_WAIT_S);
      6'd31: step_o = op(K_POLL_LOCK);
      6'd32: step_o = WR_PA;
      6'd33: step_o = wr(REG_IFACE, 8'h01);
      // calibration, also entered as a subroutine
      6'd35: step_o = wr(REG_PA, 8'h00);
      6'd36: step_o = wr(REG_CAL, 8'hB5);
      6'd37: step_o = op(K_WAIT_L);
      6'd38: step_o = op(K_POLL_CAL);
      6'd39: step_o = op(K_WAIT_S);
      6'd40: step_o = op(K_POLL_LOCK_CAL);
      6'd41: step_o = WR_PA;
      6'd42: step_o = op(K_FINAL);
      default: step_o = op(K_END);
    endcase
  end
endmodule

// File: rtl/radio_seq_cnt.sv
`timescale 1ns/1ps
module radio_seq_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/radio_mode_seq.sv
`timescale 1ns/1ps
module radio_mode_seq
  import radio_seq_pkg::*;
#(
  parameter int LONG_WAIT    = 12,
  parameter int SHORT_WAIT   = 4,
  parameter int LOCK_TIMEOUT = 5,
  parameter int LOCK_BIT     = 4,
  parameter int CAL_BIT      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [DATA_W-1:0] analog_i,
  input  logic [DATA_W-1:0] pa_i,
  output logic              req_o,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  localparam int WAIT_W = $clog2(LONG_WAIT + 1);
  localparam int POLL_W = $clog2(LOCK_TIMEOUT + 1);

  logic              busy_q, done_q, recal_q, fin_lock_q;
  logic [PC_W-1:0]   pc_q, ret_pc_q, start_pc;
  logic [2:0]        cmd_q;
  logic [DATA_W-1:0] an_q, pa_q;
  res_e              res_q, result_q;
  step_t             step;
  logic [WAIT_W-1:0] wait_cnt;
  logic [POLL_W-1:0] poll_cnt;
  logic              accept, adv, jmp_cal, ret, fin, wait_hit, poll_last;
  logic              lock_bit, is_wait, is_poll, step_chg;
  logic              unused_rd;

  assign unused_rd = ^rdata_i;

  radio_seq_rom u_rom (
    .pc_i      (pc_q),
    .cmd_i     (cmd_i),
    .step_o    (step),
    .start_pc_o(start_pc)
  );

  assign is_wait  = step.kind inside {K_WAIT_L, K_WAIT_S};
  assign is_poll  = step.kind inside {K_POLL_LOCK, K_POLL_LOCK_CAL};
  assign step_chg = !busy_q || adv || jmp_cal || ret;

  radio_seq_cnt #(.W(WAIT_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(step_chg),
    .inc_i(busy_q && is_wait), .cnt_o(wait_cnt)
  );

  radio_seq_cnt #(.W(POLL_W)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(step_chg),
    .inc_i(busy_q && is_poll && ack_i), .cnt_o(poll_cnt)
  );

  assign lock_bit  = rdata_i[LOCK_BIT];
  assign poll_last = poll_cnt == POLL_W'(LOCK_TIMEOUT - 1);
  assign wait_hit  = (step.kind == K_WAIT_L) ? (wait_cnt == WAIT_W'(LONG_WAIT - 1))
                                             : (wait_cnt == WAIT_W'(SHORT_WAIT - 1));
  assign accept    = !busy_q && cmd_valid_i && (cmd_i != 3'(CMD_NONE));

  always_comb begin
    adv = 1'b0; jmp_cal = 1'b0; ret = 1'b0; fin = 1'b0;
    if (busy_q) begin
      unique case (step.kind)
        K_WR, K_FINAL:    adv = ack_i;
        K_WAIT_L, K_WAIT_S: adv = wait_hit;
        K_POLL_CAL:       adv = ack_i && rdata_i[CAL_BIT];
        K_POLL_LOCK: begin
          adv     = ack_i && lock_bit;
          jmp_cal = ack_i && !lock_bit && poll_last;
        end
        K_POLL_LOCK_CAL:  adv = ack_i && (lock_bit || poll_last);
        K_END: begin
          ret = recal_q;
          fin = !recal_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; recal_q <= 1'b0; fin_lock_q <= 1'b0;
      pc_q <= '0; ret_pc_q <= '0; cmd_q <= '0; an_q <= '0; pa_q <= '0;
      res_q <= RES_NONE; result_q <= RES_NONE;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        pc_q       <= start_pc;
        cmd_q      <= cmd_i;
        an_q       <= analog_i;
        pa_q       <= pa_i;
        recal_q    <= 1'b0;
        fin_lock_q <= 1'b0;
        res_q      <= RES_NONE;
      end else if (busy_q) begin
        if (jmp_cal) begin
          recal_q  <= 1'b1;
          ret_pc_q <= pc_q + PC_W'(1);
          pc_q     <= PC_CAL;
        end else if (adv) begin
          pc_q <= pc_q + PC_W'(1);
        end
        if (step.kind == K_POLL_LOCK && adv) res_q <= RES_LOCK;
        if (step.kind == K_FINAL && ack_i) fin_lock_q <= lock_bit;
        if (ret) begin
          recal_q <= 1'b0;
          pc_q    <= ret_pc_q;
          res_q   <= fin_lock_q ? RES_RECAL : RES_FAIL;
        end
        if (fin) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= (cmd_q == 3'(CMD_CAL)) ? (fin_lock_q ? RES_LOCK : RES_FAIL) : res_q;
        end
      end
    end
  end

  assign req_o       = busy_q && (step.kind inside {K_WR, K_POLL_CAL, K_POLL_LOCK,
                                                    K_POLL_LOCK_CAL, K_FINAL});
  assign req_we_o    = step.kind == K_WR;
  assign req_addr_o  = step.addr;
  assign req_wdata_o = (step.src == SRC_AN) ? an_q :
                       (step.src == SRC_PA) ? pa_q : step.data;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign result_o    = result_q;
endmodule

// File: rtl/radio_mode_seq_chk.sv
`timescale 1ns/1ps
module radio_mode_seq_chk
  import radio_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_i,
  input logic              req_o,
  input logic              req_we_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              ack_i,
  input logic              busy_o,
  input logic              done_o
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_we_o) && $stable(req_addr_o) && $stable(req_wdata_o));

  // R10
  rd_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !req_we_o |-> req_addr_o == REG_STATUS);

  // R10
  wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && req_we_o |-> req_addr_o <= REG_CAL);

  // R10
  req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);

  // R11
  done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  start_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i) && ($past(cmd_i) != 3'd0));
endmodule

bind radio_mode_seq radio_mode_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_i      (cmd_i),
  .req_o      (req_o),
  .req_we_o   (req_we_o),
  .req_addr_o (req_addr_o),
  .req_wdata_o(req_wdata_o),
  .ack_i      (ack_i),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/radio_mode_seq_test.sv
`timescale 1ns/1ps
module radio_mode_seq_test;
  localparam int LW = 12, SW = 4, TO = 5;

  logic clk = 1'b0, rst_ni = 1'b0, cmd_valid_i = 1'b0, ack_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [7:0] analog_i = '0, pa_i = '0, rdata_i = '0;
  logic req_o, req_we_o, busy_o, done_o;
  logic [6:0] req_addr_o;
  logic [7:0] req_wdata_o;
  logic [1:0] result_o;

  always #4 clk = ~clk;

  radio_mode_seq #(.LONG_WAIT(LW), .SHORT_WAIT(SW), .LOCK_TIMEOUT(TO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .analog_i(analog_i), .pa_i(pa_i), .req_o(req_o), .req_we_o(req_we_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o), .ack_i(ack_i),
    .rdata_i(rdata_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nw = 0, nr = 0, ne = 0;
  int lock_after = 0, cal_wait = 0, cal_rd = 0;
  bit lock_on_cal = 0, lock_force = 0;
  logic [14:0] wlog [64];
  int          wcyc [64];
  logic [14:0] elog [64];

  // register-port slave model: ack one cycle after request, then drop
  always @(negedge clk) begin
    cyc++;
    if (ack_i) ack_i = 1'b0;
    else if (req_o && rst_ni) begin
      ack_i = 1'b1;
      if (req_we_o) begin
        if (nw < 64) begin wlog[nw] = {req_addr_o, req_wdata_o}; wcyc[nw] = cyc; end
        nw++;
        if (req_addr_o == 7'h04) begin
          cal_rd = 0;
          if (lock_on_cal) lock_force = 1;
        end
      end else begin
        rdata_i = {(cal_rd >= cal_wait), 2'b01, (lock_force || nr >= lock_after), 4'b0101};
        nr++;
        cal_rd++;
      end
    end
  end

  task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic ex(input logic [6:0] a, input logic [7:0] d);
    elog[ne] = {a, d};
    ne++;
  endtask

  task automatic cmp_writes(input string r);
    int bad;
    bad = -1;
    check(nw == ne, r, "write count", nw, ne);
    for (int i = 0; i < ne && i < nw; i++)
      if (bad < 0 && wlog[i] !== elog[i]) bad = i;
    check(bad < 0, r, "write addr/data",
          (bad < 0) ? 0 : int'(wlog[bad]), (bad < 0) ? 0 : int'(elog[bad]));
  endtask

  task automatic run(input logic [2:0] c, input logic [7:0] an, input logic [7:0] pa);
    int n;
    @(negedge clk);
    nw = 0; nr = 0; ne = 0; lock_force = 0; cal_rd = 0;
    cmd_valid_i = 1'b1; cmd_i = c; analog_i = an; pa_i = pa;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_i = '0; analog_i = ~an; pa_i = ~pa; // R13 inputs change after accept
    check(busy_o == 1'b1, "R11", "busy after accept", busy_o, 1);
    n = 0;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    check(done_o == 1'b1, "R11", "done strobe", done_o, 1);
    check(busy_o == 1'b0, "R11", "busy low at done", busy_o, 0);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R11 / R10
    check(busy_o == 0 && done_o == 0, "R11", "reset busy/done", {busy_o, done_o}, 0);
    check(req_o == 0, "R10", "reset request", req_o, 0);
    check(result_o == 0, "R11", "reset result", result_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1 power-down
    lock_after = 0; cal_wait = 0; lock_on_cal = 0;
    run(3'd1, 8'h11, 8'h22);
    ex(7'h00, 8'h1F); ex(7'h02, 8'h00); cmp_writes("R1");
    check(result_o == 0 && nr == 0, "R1", "result/reads", result_o * 100 + nr, 0);

    // R2 reset
    run(3'd2, 8'h00, 8'h00);
    ex(7'h00, 8'h0E); ex(7'h00, 8'h1F); cmp_writes("R2");

    // R3 receive wake, R13 bias captured
    run(3'd3, 8'h5A, 8'h00);
    ex(7'h00, 8'h1B); ex(7'h03, 8'h5A); ex(7'h00, 8'h19); ex(7'h00, 8'h11);
    cmp_writes("R3");
    check(wcyc[2] - wcyc[1] == LW + 1, "R3", "long wait gap", wcyc[2] - wcyc[1], LW + 1);
    check(wcyc[3] - wcyc[2] == SW + 1, "R3", "short wait gap", wcyc[3] - wcyc[2], SW + 1);

    // R4 transmit wake
    run(3'd5, 8'h3C, 8'h00);
    ex(7'h00, 8'hDB); ex(7'h03, 8'h3C); ex(7'h00, 8'hD9); ex(7'h00, 8'hD1);
    cmp_writes("R4");
    check(wcyc[2] - wcyc[1] == LW + 1, "R4", "long wait gap", wcyc[2] - wcyc[1], LW + 1);
    check(wcyc[3] - wcyc[2] == 2 * SW + 1, "R4", "double short gap", wcyc[3] - wcyc[2], 2 * SW + 1);

    // R5 / R7 sweep over every lock position inside the window
    for (int k = 0; k < TO; k++) begin
      lock_after = k;
      run(3'd4, 8'h40 + 8'(k), 8'h00);
      ex(7'h00, 8'h11); ex(7'h03, 8'h40 + 8'(k)); ex(7'h00, 8'h01); ex(7'h01, 8'h02);
      cmp_writes("R5");
      check(nr == k + 1, "R7", "lock poll reads", nr, k + 1);
      check(result_o == 1, "R7", "locked result", result_o, 1);
    end

    // R6 transmit setup, R13 amplifier captured
    lock_after = 2;
    run(3'd6, 8'h21, 8'h77);
    ex(7'h03, 8'h21); ex(7'h00, 8'hC1); ex(7'h02, 8'h77); ex(7'h01, 8'h01);
    cmp_writes("R6");
    check(nr == 3 && result_o == 1, "R6", "reads/result", nr * 10 + result_o, 31);

    // R9 receive setup times out, recalibration locks
    lock_after = 255; lock_on_cal = 1; cal_wait = 2;
    run(3'd4, 8'h0F, 8'h55);
    ex(7'h00, 8'h11); ex(7'h03, 8'h0F); ex(7'h02, 8'h00); ex(7'h04, 8'hB5);
    ex(7'h02, 8'h55); ex(7'h00, 8'h01); ex(7'h01, 8'h02);
    cmp_writes("R9");
    check(nr == TO + 5, "R9", "status reads with recal", nr, TO + 5);
    check(result_o == 2, "R9", "recal result", result_o, 2);
    repeat (10) @(negedge clk);
    check(result_o == 2, "R11", "result held", result_o, 2);

    // R9 transmit setup never locks
    lock_after = 255; lock_on_cal = 0; cal_wait = 0;
    run(3'd6, 8'h81, 8'h9A);
    ex(7'h03, 8'h81); ex(7'h00, 8'hC1); ex(7'h02, 8'h00); ex(7'h04, 8'hB5);
    ex(7'h02, 8'h9A); ex(7'h02, 8'h9A); ex(7'h01, 8'h01);
    cmp_writes("R9");
    check(nr == 2 * TO + 2, "R9", "status reads fail path", nr, 2 * TO + 2);
    check(result_o == 3, "R9", "fail result", result_o, 3);

    // R8 calibrate, sweep completion latency
    for (int w = 0; w < 4; w++) begin
      lock_after = 0; cal_wait = w;
      run(3'd7, 8'h00, 8'hC3);
      ex(7'h02, 8'h00); ex(7'h04, 8'hB5); ex(7'h02, 8'hC3);
      cmp_writes("R8");
      check(nr == w + 3, "R8", "calibrate reads", nr, w + 3);
      check(result_o == 1, "R8", "calibrate locked", result_o, 1);
    end

    // R8 calibrate without lock
    lock_after = 255; cal_wait = 0;
    run(3'd7, 8'h00, 8'h10);
    check(nr == TO + 2, "R8", "calibrate reads no lock", nr, TO + 2);
    check(result_o == 3, "R8", "calibrate failed", result_o, 3);

    // R12 command while busy ignored
    lock_after = 0;
    @(negedge clk);
    nw = 0; nr = 0; ne = 0;
    cmd_valid_i = 1'b1; cmd_i = 3'd3; analog_i = 8'h66;
    @(negedge clk); cmd_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid_i = 1'b1; cmd_i = 3'd1;
    @(negedge clk); cmd_valid_i = 1'b0; cmd_i = '0;
    for (int n = 0; n < 5000 && !done_o; n++) @(negedge clk);
    ex(7'h00, 8'h1B); ex(7'h03, 8'h66); ex(7'h00, 8'h19); ex(7'h00, 8'h11);
    cmp_writes("R12");
    repeat (20) @(negedge clk);
    check(nw == 4 && busy_o == 0, "R12", "no queued command", nw * 10 + busy_o, 40);

    // R12 code 0 ignored
    cmd_valid_i = 1'b1; cmd_i = 3'd0;
    @(negedge clk); cmd_valid_i = 1'b0;
    @(negedge clk);
    check(busy_o == 0, "R12", "code 0 ignored", busy_o, 0);
    repeat (5) @(negedge clk);
    check(nw == 4, "R12", "code 0 no traffic", nw, 4);

    finish_up();
  end
endmodule